// File: doc/BRIEF.md
# Byte Serial Peripheral Interface Controller (Master/Slave)

This block moves one byte at a time over a four-wire SPI link. The host reaches it through a small register port with three locations: control, status and data. In master mode it makes the serial clock from the system clock through a fixed prescaler. A write to the data location starts an exchange: the byte goes out on the master data output, and the byte that comes back on the master data input replaces it. In slave mode the same shift register follows an external serial clock. That clock is only taken into account while the external select input is held low.

The control byte sets the clock polarity and the clock phase. Polarity gives the level the clock rests at. Phase says whether bits are captured on the first or the second clock edge of each bit. A completion flag in the status location marks the end of each byte. The host clears the flag with a two-step sequence. While in master mode, the block can watch its select input. If another master pulls that input low, the block leaves master mode, stops the clock and raises the completion flag.

Top module: `spictl_core`

## Requirements
- R1: After reset the control byte (address 0), status byte (address 1), `sck_o` and `mosi_o` all read 0.
- R2: In master mode with no transfer running, `sck_o` rests at the polarity bit (control bit 5): high when it is 1, low when it is 0.
- R3: In master mode (control bit 7 enable = 1, bit 6 master = 1), a write to the data location (address 2) exchanges eight bits MSB first. With phase (control bit 4) = 0, bits are captured on the leading `sck_o` edge and changed on the trailing edge. With phase = 1, bits are changed on the leading edge and captured on the trailing edge. The leading edge is rising for polarity 0 and falling for polarity 1. The `sck_o` edges number exactly sixteen, and afterwards the data location reads the byte captured from `miso_i`.
- R4: The `sck_o` period in system clocks depends on double-speed (control bit 2) and rate (control bits 1:0). With double-speed = 0, rate 0, 1, 2 and 3 give 4, 16, 64 and 128. With double-speed = 1, they give 2, 8, 32 and 64.
- R5: Status bit 7 (completion flag) is 0 before the eighth capture edge of a transfer and is 1 right after it.
- R6: The flag clears only on a data-location access that follows a strobed status read made while the flag was 1. A data access without that prior status read leaves the flag set.
- R7: In slave mode (enable = 1, master = 0), while `ss_n_i` is low, the block exchanges eight bits MSB first on `sck_i`, with the same edge rules as R3. It sets the flag, and the data location then holds the byte taken from `mosi_i`.
- R8: In slave mode with phase = 0, the MSB of the loaded byte appears on `miso_o` after `ss_n_i` falls and before the first `sck_i` edge.
- R9: The rate and double-speed bits do not change slave-mode behaviour.
- R10: When enable, master and select-watch (control bit 3) are all 1 and `ss_n_i` goes low, the master bit clears, the flag sets and `sck_o` returns to its rest level.
- R11: With enable = 0, a data write starts no transfer: `sck_o` does not move and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | External serial clock in slave mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| ss_n_i | input | 1 | Select input, active low |
| miso_o | output | 1 | Serial data out in slave mode |

## Verification
Master transfers are run for all eight prescaler settings and under random polarity, phase and data. The bench counts system clocks between like edges, which separates each divider setting from its neighbours. It also checks that capture and change fall on the proper edge: a phase error would shift every received bit by one.

Slave transfers are driven by a bench model of the remote master, using random rate bits to show that they are ignored. The phase-0 case checks separately that the first bit is driven before any clock edge.

Directed cases cover:
- the flag-clear order, with and without the status read first;
- a disabled block;
- a mode fault in the middle of a byte.

// File: rtl/spictl_pkg.sv
package spictl_pkg;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   typedef struct packed {
      logic       en;
      logic       master;
      logic       cpol;
      logic       cpha;
      logic       ss_watch;
      logic       dbl;
      logic [1:0] rate;
   } ctrl_t;

   // log2 of the SCK half period in system clocks
   function automatic logic [2:0] half_exp(input logic dbl, input logic [1:0] rate);
      logic [3:0] base;
      base = (rate == 2'd3) ? 4'd7 : (4'({rate, 1'b0}) + 4'd2);
      return 3'(base - {3'b000, dbl} - 4'd1);
   endfunction

endpackage

// File: rtl/spictl_sync.sv
module spictl_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spictl_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/spictl_rate_gen.sv
module spictl_rate_gen
   import spictl_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       dbl,
   input  logic [1:0] rate,
   output logic       tick
);

   if (CNT_W < 6) begin : g_bad_cnt
      $error("spictl_rate_gen: CNT_W must hold a half period of 64");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;

   assign half_m1 = CNT_W'((32'd1 << half_exp(dbl, rate)) - 32'd1);
   assign tick    = run && (cnt == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   // R4: the counter restarts after every SCK edge
   p_tick_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));

endmodule

// File: rtl/spictl_shift.sv
module spictl_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         sample_en,
   input  logic         in_bit,
   input  logic         setup_en,
   input  logic         prime,
   output logic [W-1:0] sr_o,
   output logic         dout_o
);

   if (W < 2) begin : g_bad_w
      $error("spictl_shift: W must be at least 2");
   end

   logic [W-1:0] sr;
   logic         dout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         dout <= 1'b0;
      end else if (load) begin
         sr   <= load_val;
         dout <= load_val[W-1];
      end else begin
         if (sample_en)         sr   <= {sr[W-2:0], in_bit};
         if (setup_en || prime) dout <= sr[W-1];
      end
   end

   assign sr_o   = sr;
   assign dout_o = dout;

   // R3: the register only moves on a load or a capture edge
   p_sr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !sample_en) |=> $stable(sr));

endmodule

// File: rtl/spictl_core.sv
module spictl_core
   import spictl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i,
   input  logic              sck_i,
   input  logic              mosi_i,
   input  logic              ss_n_i,
   output logic              miso_o
);

   localparam int EC_W = $clog2(2 * DATA_W);
   localparam int BC_W = $clog2(DATA_W);
   localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * DATA_W - 1);
   localparam logic [BC_W-1:0] LAST_BIT  = BC_W'(DATA_W - 1);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("spictl_core: DATA_W must be at least 8");
   end

   ctrl_t           ctrl;
   logic            flag, armed;
   logic            busy, phase;
   logic [EC_W-1:0] edge_cnt;
   logic [BC_W-1:0] scnt;
   logic            tick;
   logic            sck_s, mosi_s, ss_s, sck_q, ss_q;
   logic [DATA_W-1:0] sr;
   logic            dout;

   // ---------------- input synchronisation ----------------
   spictl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck_i, mosi_i, ss_n_i}),
      .q     ({sck_s, mosi_s, ss_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         ss_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         ss_q  <= ss_s;
      end
   end

   // ---------------- bus decode ----------------
   logic wr_ctrl, wr_data, rd_stat, data_acc;
   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
   assign rd_stat  = bus_rd && (bus_addr == ADDR_STAT);
   assign data_acc = (bus_rd || bus_wr) && (bus_addr == ADDR_DATA);

   logic load, start, fault;
   assign load  = wr_data && !busy;
   assign start = load && ctrl.en && ctrl.master;
   assign fault = ctrl.en && ctrl.master && ctrl.ss_watch && !ss_s;

   // ---------------- slave edge decode ----------------
   logic sck_rise, sck_fall, ss_fall, slave_act;
   logic s_lead, s_trail, s_sample, s_setup, s_prime, s_done;
   assign sck_rise  = sck_s && !sck_q;
   assign sck_fall  = !sck_s && sck_q;
   assign ss_fall   = !ss_s && ss_q;
   assign slave_act = ctrl.en && !ctrl.master && !ss_s;
   assign s_lead    = slave_act && (ctrl.cpol ? sck_fall : sck_rise);
   assign s_trail   = slave_act && (ctrl.cpol ? sck_rise : sck_fall);
   assign s_sample  = ctrl.cpha ? s_trail : s_lead;
   assign s_setup   = ctrl.cpha ? s_lead  : s_trail;
   assign s_prime   = ctrl.en && !ctrl.master && ss_fall && !ctrl.cpha;
   assign s_done    = s_sample && (scnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          scnt <= '0;
      else if (!slave_act) scnt <= '0;
      else if (s_sample)   scnt <= s_done ? '0 : scnt + 1'b1;
   end

   // ---------------- master sequencing ----------------
   logic m_lead, m_trail, m_sample, m_setup, m_done;
   assign m_lead   = tick && !edge_cnt[0];
   assign m_trail  = tick && edge_cnt[0];
   assign m_sample = ctrl.cpha ? m_trail : m_lead;
   assign m_setup  = ctrl.cpha ? m_lead  : m_trail;
   assign m_done   = m_sample && (edge_cnt[EC_W-1:1] == LAST_EDGE[EC_W-1:1]);

   spictl_rate_gen #(.CNT_W(CNT_W)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .dbl   (ctrl.dbl),
      .rate  (ctrl.rate),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         phase    <= 1'b0;
         edge_cnt <= '0;
      end else if (!ctrl.en || !ctrl.master || fault) begin
         busy     <= 1'b0;
         phase    <= 1'b0;
         edge_cnt <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         phase    <= 1'b0;
         edge_cnt <= '0;
      end else if (tick) begin
         phase    <= !phase;
         edge_cnt <= edge_cnt + 1'b1;
         if (edge_cnt == LAST_EDGE) busy <= 1'b0;
      end
   end

   // ---------------- shared shift engine ----------------
   spictl_shift #(.W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_val  (bus_wdata),
      .sample_en (m_sample || s_sample),
      .in_bit    (ctrl.master ? miso_i : mosi_s),
      .setup_en  (m_setup || s_setup),
      .prime     (s_prime),
      .sr_o      (sr),
      .dout_o    (dout)
   );

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[7:0]);
         if (fault)   ctrl.master <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else if (m_done || s_done || fault) begin
         flag  <= 1'b1;
         armed <= 1'b0;
      end else if (armed && data_acc) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else if (rd_stat && flag) begin
         armed <= 1'b1;
      end
   end

   always_comb begin
      case (bus_addr)
         ADDR_CTRL: bus_rdata = DATA_W'(ctrl);
         ADDR_STAT: bus_rdata = DATA_W'({flag, 7'b0});
         ADDR_DATA: bus_rdata = sr;
         default:   bus_rdata = '0;
      endcase
   end

   assign sck_o  = ctrl.cpol ^ phase;
   assign mosi_o = dout;
   assign miso_o = dout;

   // ---------------- assertions ----------------
   // R2: no clock activity outside a transfer
   p_idle_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !phase);
   // R5: last capture edge raises the flag
   p_flag_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_done || s_done) |=> flag);
   // R6: the flag only falls through the read-then-access sequence
   p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(armed && data_acc));
   // R10: a mode fault drops master mode and raises the flag
   p_fault_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!ctrl.master && flag && !busy));
   // R11: a disabled block never runs
   p_no_run_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |=> !busy);

endmodule

// File: tb/sim_spictl_core.sv
`timescale 1ns/1ps
module sim_spictl_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       sck_o, mosi_o, miso_o;
   logic       miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
   int         checks = 0, errors = 0, cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   spictl_core u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
      .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o)
   );

   function automatic int exp_div(input logic dbl, input logic [1:0] rate);
      int d;
      case (rate)
         2'd0: d = 4;
         2'd1: d = 16;
         2'd2: d = 64;
         default: d = 128;
      endcase
      return dbl ? d / 2 : d;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1; v = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic flag_clear_seq(input string tag);
      logic [7:0] v;
      bus_read(2'd2, v);             // data access without prior status read
      bus_addr = 2'd1; #1;
      chk(bus_rdata[7] === 1'b1, {tag, " R6 flag kept"}, bus_rdata[7], 1);
      bus_read(2'd1, v);
      bus_read(2'd2, v);
      bus_addr = 2'd1; #1;
      chk(bus_rdata[7] === 1'b0, {tag, " R6 flag cleared"}, bus_rdata[7], 0);
   endtask

   task automatic m_xfer(input logic cpol, input logic cpha, input logic dbl,
                         input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] rx);
      logic [7:0] got, v;
      logic       prev;
      int edges, nsamp, t0, t2, wc;
      bit early, at8;
      bus_write(2'd0, {1'b1, 1'b1, cpol, cpha, 1'b0, dbl, rate});
      @(negedge clk);
      chk(sck_o === cpol, "R2 idle level", sck_o, cpol);
      miso_i = rx[7];
      bus_write(2'd2, tx);
      bus_addr = 2'd1;
      prev = sck_o; edges = 0; nsamp = 0; got = 8'd0; wc = 0; t0 = 0; t2 = 0;
      early = 1'b0; at8 = 1'b0;
      while (edges < 16 && wc < 4000) begin
         @(negedge clk); wc++;
         if (sck_o !== prev) begin
            prev = sck_o;
            if (edges == 0) t0 = cyc;
            if (edges == 2) t2 = cyc;
            if (((edges % 2) == 0) ^ cpha) begin
               got = {got[6:0], mosi_o};
               nsamp++;
               if (nsamp < 8 && bus_rdata[7]) early = 1'b1;
               if (nsamp == 8) at8 = bus_rdata[7];
            end else if (nsamp < 8) begin
               miso_i = rx[7 - nsamp];
            end
            edges++;
         end else if (nsamp < 8 && bus_rdata[7]) begin
            early = 1'b1;
         end
      end
      repeat (3) @(negedge clk);
      chk(edges == 16, "R3 edge count", edges, 16);
      chk(got === tx, "R3 mosi byte", got, tx);
      chk((t2 - t0) == exp_div(dbl, rate), "R4 sck period", t2 - t0, exp_div(dbl, rate));
      chk(!early && at8, "R5 flag timing", {early, at8}, 1);
      chk(sck_o === cpol, "R2 rest after transfer", sck_o, cpol);
      bus_read(2'd2, v);
      chk(v === rx, "R3 received byte", v, rx);
      flag_clear_seq("master");
   endtask

   task automatic s_xfer(input logic cpol, input logic cpha, input logic dbl,
                         input logic [1:0] rate, input logic [7:0] htx, input logic [7:0] mtx);
      logic [7:0] got, v;
      bus_write(2'd0, {1'b1, 1'b0, cpol, cpha, 1'b0, dbl, rate});
      bus_write(2'd2, htx);
      sck_i = cpol;
      repeat (6) @(negedge clk);
      ss_n_i = 1'b0; got = 8'd0;
      for (int i = 0; i < 8; i++) begin
         if (!cpha) begin
            mosi_i = mtx[7 - i];
            repeat (8) @(negedge clk);
            got = {got[6:0], miso_o};
            if (i == 0) chk(miso_o === htx[7], "R8 first bit before clock", miso_o, htx[7]);
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
            sck_i = ~sck_i;
         end else begin
            sck_i = ~sck_i;
            mosi_i = mtx[7 - i];
            repeat (8) @(negedge clk);
            got = {got[6:0], miso_o};
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
         end
      end
      repeat (8) @(negedge clk);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
      chk(got === htx, "R7 R9 miso byte", got, htx);
      bus_addr = 2'd1; #1;
      chk(bus_rdata[7] === 1'b1, "R7 flag set", bus_rdata[7], 1);
      bus_read(2'd2, v);
      chk(v === mtx, "R7 R9 received byte", v, mtx);
      flag_clear_seq("slave");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic       prev;
      bit         moved;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_addr = 2'd0; #1;
      chk(bus_rdata === 8'd0, "R1 control reset", bus_rdata, 0);
      bus_addr = 2'd1; #1;
      chk(bus_rdata === 8'd0, "R1 status reset", bus_rdata, 0);
      chk(sck_o === 1'b0 && mosi_o === 1'b0, "R1 pins reset", {sck_o, mosi_o}, 0);

      // R11 disabled block
      bus_write(2'd0, 8'b0110_0000);
      bus_write(2'd2, 8'hA5);
      prev = sck_o; moved = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (sck_o !== prev) moved = 1'b1;
      end
      bus_addr = 2'd1; #1;
      chk(!moved && sck_o === 1'b1, "R11 no clock when disabled", moved, 0);
      chk(bus_rdata[7] === 1'b0, "R11 no flag when disabled", bus_rdata[7], 0);

      // R4 every prescaler setting, R3 under mixed modes
      for (int k = 0; k < 8; k++)
         m_xfer(k[0], k[1], k[2], k[1:0], 8'h5A ^ 8'(k * 37), 8'hC3 ^ 8'(k * 11));

      // random master transfers
      for (int k = 0; k < 10; k++) begin
         logic [3:0] r;
         r = 4'($urandom);
         m_xfer(r[0], r[1], r[2], {r[3], r[0]}, 8'($urandom), 8'($urandom));
      end

      // slave: directed phase-0 case with a distinct first bit, then random
      s_xfer(1'b0, 1'b0, 1'b0, 2'd0, 8'h81, 8'h3C);
      s_xfer(1'b1, 1'b1, 1'b1, 2'd3, 8'h7E, 8'hD2);
      for (int k = 0; k < 8; k++) begin
         logic [3:0] r;
         r = 4'($urandom);
         s_xfer(r[0], r[1], r[2], {r[3], r[1]}, 8'($urandom), 8'($urandom));
      end

      // R10 mode fault during a master transfer
      bus_write(2'd0, 8'b1110_1001);
      bus_write(2'd2, 8'h55);
      repeat (20) @(negedge clk);
      ss_n_i = 1'b0;
      repeat (6) @(negedge clk);
      bus_read(2'd0, v);
      chk(v[6] === 1'b0, "R10 master bit cleared", v[6], 0);
      chk(sck_o === 1'b1, "R10 clock at rest", sck_o, 1);
      bus_read(2'd1, v);
      chk(v[7] === 1'b1, "R10 flag set", v[7], 1);
      ss_n_i = 1'b1;
      bus_read(2'd2, v);
      bus_addr = 2'd1; #1;
      chk(bus_rdata[7] === 1'b0, "R6 flag cleared after fault", bus_rdata[7], 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule